// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital side of a multiplexed analog-to-digital converter. Software writes a control word holding a repeat-mode bit and a 5-bit input code. The block turns that code into a one-hot select for the analog multiplexer and issues single-cycle start pulses to the converter. It captures each 8-bit result into a data register and sets a completion flag. With the repeat bit set, it starts the next conversion as soon as a result lands. With the bit clear, it stops after one result.

The all-ones input code is a power-down command. While it is selected, the converter enable is low, the mux select is all zero, and no conversions start. Selecting a real code after power-down arms a stabilisation step: the first conversion that finishes is thrown away without touching the data register or the flag, and a fresh conversion starts at once. A control write always cancels the conversion in flight and restarts on the new code, unless the new code is the power-down code. The converter is modelled as a start pulse followed, some cycles later, by a done pulse carrying the result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the repeat bit reads 0, the input code reads 11111, and the flag, data register, start, power enable and mux select are all 0.
- R2: mux_sel follows the stored code from the cycle after a write: codes 0-7 set bit 0-7, codes 8, 9, 10, 11 set bits 11, 10, 9, 8, code 29 (11101) sets bit 12 (high reference), code 30 (11110) sets bit 13 (low reference), and every other code gives all zero.
- R3: A write with a code other than 11111 drives cv_start high in the following cycle and clears the flag.
- R4: While the stored code is 11111, cv_pwr_en is 0, cv_start stays 0, and a done pulse changes neither the data register nor the flag.
- R5: The first done pulse after leaving code 11111 is discarded: the data register and the flag are unchanged, and cv_start is driven in the next cycle.
- R6: A done pulse during an active, non-discarded conversion loads cv_data into the data register and sets the flag, both visible in the next cycle.
- R7: With the repeat bit 0, no start follows a loaded result, and a done pulse while idle is ignored.
- R8: With the repeat bit 1, cv_start is driven in the cycle after each loaded result.
- R9: data_rd clears the flag in the next cycle unless a result loads in the same cycle, in which case the flag is set. A write also clears the flag.
- R10: A write during a conversion cancels it: a done pulse arriving in the same cycle as the write is ignored, and the new conversion starts in the next cycle.
- R11: rd_cont and rd_chan return the stored repeat bit and code, and rd_flag returns the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| wr_cont | input | 1 | Repeat-mode bit to write |
| wr_chan | input | 5 | Input code to write |
| data_rd | input | 1 | Read strobe of the data register |
| cv_done | input | 1 | Converter finished pulse |
| cv_data | input | 8 | Converter result, valid with cv_done |
| cv_start | output | 1 | Start pulse to converter |
| cv_pwr_en | output | 1 | Converter power enable |
| mux_sel | output | 14 | One-hot analog input select |
| result | output | 8 | Data register |
| rd_cont | output | 1 | Stored repeat bit |
| rd_chan | output | 5 | Stored input code |
| rd_flag | output | 1 | Completion flag |

## Verification
A wrong stored code shows at once on mux_sel, cv_pwr_en and rd_chan in the cycle after the write. A wrong busy or discard state has no immediate effect. It shows at the next done pulse, as a result loaded when it should be dropped, a missing restart, or an extra start one cycle later. For that reason, the bench compares every output against its reference model on every clock, so a divergence is reported in the first cycle it becomes visible at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CHAN_W  = 5;
    localparam int DATA_W  = 8;
    localparam int N_SEL   = 14;
    localparam int N_PORTB = 8;
    localparam int N_PORTD = 4;
    localparam logic [CHAN_W-1:0] CODE_OFF  = {CHAN_W{1'b1}};
    localparam logic [CHAN_W-1:0] CODE_VHI  = CODE_OFF - 2;
    localparam logic [CHAN_W-1:0] CODE_VLO  = CODE_OFF - 1;

    typedef struct packed {
        logic              cont;
        logic [CHAN_W-1:0] chan;
        logic              flag;
        logic [DATA_W-1:0] data;
        logic              busy;
        logic              settle;
        logic              start;
    } seq_state_t;

    // Input code that drives select bit idx
    function automatic logic [CHAN_W-1:0] code_of_bit(input int idx);
        if (idx < N_PORTB)
            return CHAN_W'(idx);
        else if (idx < N_PORTB + N_PORTD)
            return CHAN_W'(2 * N_PORTB + N_PORTD - 1 - idx);
        else if (idx == N_PORTB + N_PORTD)
            return CODE_VHI;
        else
            return CODE_VLO;
    endfunction
endpackage

// File: rtl/adc_mux_decode.sv
module adc_mux_decode
    import adc_seq_pkg::*;
(
    input  logic [CHAN_W-1:0] code_i,
    output logic [N_SEL-1:0]  sel_o
);
    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        localparam logic [CHAN_W-1:0] MATCH = code_of_bit(g);
        assign sel_o[g] = (code_i == MATCH);
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              wr_cont,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              data_rd,
    input  logic              cv_done,
    input  logic [DATA_W-1:0] cv_data,
    output logic              start_o,
    output logic              cont_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] data_o
);
    seq_state_t st_d, st_q;
    logic       off_new;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        off_new    = (wr_chan == CODE_OFF);
        if (reg_wr) begin
            st_d.cont = wr_cont;
            st_d.chan = wr_chan;
            st_d.flag = 1'b0;
            if (off_new) begin
                st_d.busy   = 1'b0;
                st_d.settle = 1'b0;
            end else begin
                st_d.busy   = 1'b1;
                st_d.start  = 1'b1;
                st_d.settle = st_q.settle | (st_q.chan == CODE_OFF);
            end
        end else begin
            if (data_rd)
                st_d.flag = 1'b0;
            if (st_q.busy && cv_done) begin
                if (st_q.settle) begin
                    st_d.settle = 1'b0;
                    st_d.start  = 1'b1;
                end else begin
                    st_d.data = cv_data;
                    st_d.flag = 1'b1;
                    if (st_q.cont)
                        st_d.start = 1'b1;
                    else
                        st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.chan <= CODE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign cont_o  = st_q.cont;
    assign chan_o  = st_q.chan;
    assign flag_o  = st_q.flag;
    assign data_o  = st_q.data;

    p_no_start_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> (st_q.chan != CODE_OFF));
    p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> ($past(reg_wr) || $past(cv_done)));
    p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> ($past(cv_done) && !$past(reg_wr)));
    p_data_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.data != $past(st_q.data)) |-> $past(cv_done));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              wr_cont,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              data_rd,
    input  logic              cv_done,
    input  logic [DATA_W-1:0] cv_data,
    output logic              cv_start,
    output logic              cv_pwr_en,
    output logic [N_SEL-1:0]  mux_sel,
    output logic [DATA_W-1:0] result,
    output logic              rd_cont,
    output logic [CHAN_W-1:0] rd_chan,
    output logic              rd_flag
);
    logic [CHAN_W-1:0] chan_q;

    adc_seq_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_wr  (reg_wr),
        .wr_cont (wr_cont),
        .wr_chan (wr_chan),
        .data_rd (data_rd),
        .cv_done (cv_done),
        .cv_data (cv_data),
        .start_o (cv_start),
        .cont_o  (rd_cont),
        .chan_o  (chan_q),
        .flag_o  (rd_flag),
        .data_o  (result)
    );

    adc_mux_decode i_dec (
        .code_i (chan_q),
        .sel_o  (mux_sel)
    );

    assign cv_pwr_en = (chan_q != CODE_OFF);
    assign rd_chan   = chan_q;

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mux_sel));
    p_off_no_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cv_pwr_en |-> (mux_sel == '0));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       wr_cont = 1'b0;
    logic [4:0] wr_chan = 5'd0;
    logic       data_rd = 1'b0;
    logic       conv_done = 1'b0;
    logic       stray_done = 1'b0;
    logic [7:0] cv_data = 8'h00;
    wire        cv_done = conv_done | stray_done;
    logic        cv_start, cv_pwr_en, rd_cont, rd_flag;
    logic [13:0] mux_sel;
    logic [7:0]  result;
    logic [4:0]  rd_chan;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_cont(wr_cont),
        .wr_chan(wr_chan), .data_rd(data_rd), .cv_done(cv_done),
        .cv_data(cv_data), .cv_start(cv_start), .cv_pwr_en(cv_pwr_en),
        .mux_sel(mux_sel), .result(result), .rd_cont(rd_cont),
        .rd_chan(rd_chan), .rd_flag(rd_flag)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int starts = 0;
    int loads = 0;
    int lat = 3;
    int cnt = 0;
    bit done_flag = 0;

    // reference model state
    bit       m_cont, m_flag, m_busy, m_settle, m_start;
    int       m_chan;
    bit [7:0] m_data;

    function automatic int exp_sel(input int c);
        if (c < 8)  return 1 << c;
        if (c < 12) return 1 << (19 - c);
        if (c == 29) return 1 << 12;
        if (c == 30) return 1 << 13;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cont = 0; m_chan = 31; m_flag = 0; m_data = 0;
            m_busy = 0; m_settle = 0; m_start = 0;
        end else begin
            bit was_off;
            was_off = (m_chan == 31);
            m_start = 0;
            if (reg_wr) begin
                m_cont = wr_cont;
                m_chan = wr_chan;
                m_flag = 0;
                if (wr_chan == 5'd31) begin
                    m_busy = 0; m_settle = 0;
                end else begin
                    m_busy = 1; m_start = 1;
                    if (was_off) m_settle = 1;
                end
            end else begin
                if (data_rd) m_flag = 0;
                if (m_busy && cv_done) begin
                    if (m_settle) begin
                        m_settle = 0; m_start = 1;
                    end else begin
                        m_data = cv_data; m_flag = 1; loads++;
                        if (m_cont) m_start = 1; else m_busy = 0;
                    end
                end
            end
        end
    end

    // per-cycle compare, then converter model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R3 cv_start", cv_start, m_start);
            chk("R4 cv_pwr_en", cv_pwr_en, m_chan != 31);
            chk("R2 mux_sel", mux_sel, exp_sel(m_chan));
            chk("R6 result", result, m_data);
            chk("R9 rd_flag", rd_flag, m_flag);
            chk("R11 rd_cont", rd_cont, m_cont);
            chk("R11 rd_chan", rd_chan, m_chan);
        end
        conv_done = 0;
        if (cv_start) begin
            starts++;
            cnt = lat;
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                conv_done = 1;
                cv_data = cv_data + 8'h17;
            end
        end
        if (cycles > 100000 && !done_flag) begin
            done_flag = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_ctl(input bit c, input int code);
        @(negedge clk);
        reg_wr = 1; wr_cont = c; wr_chan = 5'(code);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int s0, l0;
        bit [7:0] d0;
        idle(3);
        // R1: reset state
        chk("R1 pwr", cv_pwr_en, 0);
        chk("R1 start", cv_start, 0);
        chk("R1 mux", mux_sel, 0);
        chk("R1 flag", rd_flag, 0);
        chk("R1 data", result, 0);
        chk("R1 chan", rd_chan, 31);
        chk("R1 cont", rd_cont, 0);
        @(negedge clk); rst_n = 1;
        idle(4);
        chk("R1 still off", cv_pwr_en, 0);

        // R2 / R10: sweep all codes, writes land mid-conversion
        for (int c = 0; c < 31; c++) begin
            write_ctl(0, c);
            chk("R2 decode", mux_sel, exp_sel(c));
            chk("R3 start after write", cv_start, 1);
            idle(1);
        end
        idle(10);

        // R4: power down, done ignored
        write_ctl(0, 31);
        d0 = result;
        s0 = starts;
        idle(3);
        stray_done = 1; @(negedge clk); stray_done = 0;
        idle(8);
        chk("R4 no start off", starts - s0, 0);
        chk("R4 data kept", result, d0);
        chk("R4 flag clear", rd_flag, 0);

        // R5 / R7: leave power-down, single conversion
        s0 = starts; l0 = loads;
        write_ctl(0, 3);
        idle(lat + 1);
        chk("R5 discard no flag", rd_flag, 0);
        chk("R5 discard data", result, d0);
        idle(lat + 4);
        chk("R6 loaded", loads - l0, 1);
        chk("R6 flag set", rd_flag, 1);
        chk("R7 two starts", starts - s0, 2);
        d0 = result;
        stray_done = 1; @(negedge clk); stray_done = 0;
        idle(10);
        chk("R7 idle done ignored", result, d0);
        chk("R7 no more starts", starts - s0, 2);

        // R9: read clears flag
        @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
        chk("R9 read clears", rd_flag, 0);

        // R8: repeat mode, no settle needed
        l0 = loads; lat = 2;
        write_ctl(1, 9);
        for (int k = 0; k < 40; k++) begin
            data_rd = (k % 3 == 0);
            @(negedge clk);
        end
        data_rd = 0;
        chk("R8 repeated loads", (loads - l0) >= 10, 1);

        // R10: rewrite during repeat, then stop
        write_ctl(1, 29);
        idle(1);
        write_ctl(1, 5);
        idle(12);
        write_ctl(0, 30);
        idle(10);
        write_ctl(1, 31);
        idle(5);
        write_ctl(1, 11);
        idle(20);
        write_ctl(0, 31);
        idle(5);
        chk("R4 final off", cv_pwr_en, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule